// File: doc/BRIEF.md
# Dual-Writer Byte-Lane RAM with Collision Priority

This block is a small single-clock RAM with two write ports and one registered read port. Port A writes selected byte lanes: a lane is stored only when the clock enable, the port's write enable and that lane's bit of its byte-enable vector are all high. Port B always writes the full word. Both writers may target different addresses in the same cycle. When they target the same address, a parameter chooses which of them keeps the overlapping lanes.

The read port has one cycle of latency. Each write port carries its own parameter for what a read of the same cell in the same cycle returns: the stored value from before the write, the value being written, or an unspecified value. This lets the RAM stand in for storage whose read-during-write behaviour differs from port to port.

A shared clock enable gates both writes and the read. A synchronous active-low reset clears only the read data register. The memory array keeps its contents through reset and starts with unspecified contents.

Top module: `dual_wr_ram`

## Requirements
- R1: While rst_n is low at a rising clock edge, rd_data becomes all zero at that edge, whatever the other inputs are.
- R2: When clk_en and rd_en are both 1 at an edge, rd_data shows the word at rd_addr after that edge (one cycle of latency). Otherwise rd_data keeps its value.
- R3: Byte lane i of port A covers data bits i*BYTE_W up to i*BYTE_W+BYTE_W-1. It is written only when clk_en, a_we and a_be[i] are all 1. Lanes whose enable bit is 0 keep their stored value.
- R4: Port B writes every lane of b_wdata at b_addr when clk_en and b_we are both 1.
- R5: When clk_en is 0, neither port changes the memory and rd_data holds.
- R6: When the two ports write different addresses in the same cycle, both writes are stored.
- R7: When both ports write the same address in one cycle, the PRIO parameter picks the lane owner. With 0 (port A wins), the lanes A enables take A's data. With 1 (port B wins), every lane takes B's data. With 2 (no priority), the lanes both ports write are left unspecified. Lanes only one port writes take that port's data.
- R8: For a read of a cell that a single port writes in the same cycle, that port's view parameter decides the result for each written lane. Value 1 returns the written data, value 0 returns the value held before the write, and value 2 leaves the result unspecified. Lanes that are not written return the stored value.
- R9: When both ports collide on the cell being read, each lane that both ports write follows the view setting of the winning port. If no priority is set, that lane is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Synchronous active-low reset of the read register |
| clk_en | input | 1 | Common clock enable for both writes and the read |
| a_we | input | 1 | Port A global write enable |
| a_be | input | LANES | Port A byte-lane enables |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| b_we | input | 1 | Port B full-word write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench runs three parameter sets side by side: A wins with A reading new and B reading old, B wins with the views swapped, and no priority. It targets same-address collisions with partial byte enables. A design that resolved these per word instead of per lane would lose B's data in lanes A left disabled. Reads of a cell being written in the same cycle are checked under both views. A wrong forwarding path would return the stale word where the new one is expected, or the other way round. Collisions at the read address also check that read-through follows the winner and not the loser. Cycles with the clock enable low and a byte enable low but the write enable high are included, so that a missing qualifier shows up as a corrupted word on a later read.

// File: rtl/dwr_pkg.sv
// Shared types for the dual-writer RAM.
// Assumes: used only as parameter types; carries no logic.
package dwr_pkg;

    // Which write port keeps a lane when both write one address.
    typedef enum logic [1:0] {
        PRIO_A    = 2'd0,
        PRIO_B    = 2'd1,
        PRIO_NONE = 2'd2
    } dwr_prio_e;

    // What a same-cycle read sees of a lane this port is writing.
    typedef enum logic [1:0] {
        SEE_OLD = 2'd0,
        SEE_NEW = 2'd1,
        SEE_ANY = 2'd2
    } dwr_view_e;

endpackage

// File: rtl/dwr_wr_arbiter.sv
// Qualifies both write ports into per-lane write strobes and removes the
// losing port's strobes on lanes where both ports hit one address.
// Assumes: with PRIO_NONE the colliding lanes are unspecified, so port B is
// left to store them (any choice is legal).
module dwr_wr_arbiter #(
    parameter int                 ADDR_W = 4,
    parameter int                 LANES  = 2,
    parameter dwr_pkg::dwr_prio_e PRIO   = dwr_pkg::PRIO_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              a_we,
    input  logic [LANES-1:0]  a_be,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [LANES-1:0]  a_lane_we,
    output logic [LANES-1:0]  b_lane_we
);

    logic [LANES-1:0] a_raw;
    logic [LANES-1:0] b_raw;
    logic [LANES-1:0] overlap;

    // Raw strobes: clock enable, port enable and lane enable combined.
    always_comb begin
        a_raw   = a_be & {LANES{clk_en & a_we}};
        b_raw   = {LANES{clk_en & b_we}};
        overlap = (a_addr == b_addr) ? (a_raw & b_raw) : '0;
    end

    // Priority variant picked by parameter: the loser gives up overlapping lanes.
    generate
        if (PRIO == dwr_pkg::PRIO_A) begin : g_a_wins
            assign a_lane_we = a_raw;
            assign b_lane_we = b_raw & ~overlap;

            AST_A_KEEPS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && a_we && b_we && a_addr == b_addr) |-> (a_lane_we == a_be)); // R7
        end else begin : g_b_stores
            assign a_lane_we = a_raw & ~overlap;
            assign b_lane_we = b_raw;

            AST_B_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && b_we && a_addr == b_addr) |-> (a_lane_we == '0)); // R7
        end
    endgenerate

    AST_CLKEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (a_lane_we == '0 && b_lane_we == '0)); // R5
    AST_BE_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_lane_we & ~a_be) == '0) && (a_we || a_lane_we == '0)); // R3

endmodule

// File: rtl/dwr_storage.sv
// Memory array with two lane-granular write ports and a combinational read
// of the stored word for the registered read stage.
// Assumes: the arbiter never strobes the same lane of one address from both
// ports; the contents are not reset.
module dwr_storage #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  a_lane_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [LANES-1:0]  b_lane_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane writes from both ports; their strobes never overlap on one cell.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (b_lane_we[i]) mem[b_addr][i*BYTE_W +: BYTE_W] <= b_wdata[i*BYTE_W +: BYTE_W];
            if (a_lane_we[i]) mem[a_addr][i*BYTE_W +: BYTE_W] <= a_wdata[i*BYTE_W +: BYTE_W];
        end
    end

    // Pre-write word at the read address.
    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/dwr_read_port.sv
// Registered read port. Each lane takes the stored word, or the write data
// of a port set to SEE_NEW that writes this lane of the read address.
// Assumes: the lane strobes come from the arbiter, so at most one port
// strobes any lane of one address; SEE_OLD and SEE_ANY both return old data.
module dwr_read_port #(
    parameter int                 ADDR_W = 4,
    parameter int                 DATA_W = 16,
    parameter int                 BYTE_W = 8,
    parameter dwr_pkg::dwr_view_e VIEW_A = dwr_pkg::SEE_NEW,
    parameter dwr_pkg::dwr_view_e VIEW_B = dwr_pkg::SEE_OLD,
    localparam int                LANES  = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [LANES-1:0]  a_lane_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [LANES-1:0]  b_lane_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam bit A_FWD = (VIEW_A == dwr_pkg::SEE_NEW);
    localparam bit B_FWD = (VIEW_B == dwr_pkg::SEE_NEW);

    logic [DATA_W-1:0] rd_next;
    logic              a_hit;
    logic              b_hit;

    assign a_hit = (a_addr == rd_addr);
    assign b_hit = (b_addr == rd_addr);

    // One forwarding mux per byte lane.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            // Picks the lane source: a forwarding writer, else the stored lane.
            always_comb begin
                if (A_FWD && a_lane_we[i] && a_hit)
                    rd_next[i*BYTE_W +: BYTE_W] = a_wdata[i*BYTE_W +: BYTE_W];
                else if (B_FWD && b_lane_we[i] && b_hit)
                    rd_next[i*BYTE_W +: BYTE_W] = b_wdata[i*BYTE_W +: BYTE_W];
                else
                    rd_next[i*BYTE_W +: BYTE_W] = rd_word[i*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    // Output register: reset clears it, an enabled read loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (clk_en && rd_en)
            rd_data <= rd_next;
    end

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && rd_en) |=> $stable(rd_data)); // R2

    generate
        if (VIEW_A == dwr_pkg::SEE_NEW) begin : g_a_new
            AST_A_READS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && rd_en && a_lane_we == '1 && a_hit) |=> (rd_data == $past(a_wdata))); // R8
        end else if (VIEW_A == dwr_pkg::SEE_OLD) begin : g_a_old
            AST_A_READS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && rd_en && a_lane_we == '1 && a_hit) |=> (rd_data == $past(rd_word))); // R8
        end
        if (VIEW_B == dwr_pkg::SEE_NEW) begin : g_b_new
            AST_B_READS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && rd_en && b_lane_we == '1 && b_hit) |=> (rd_data == $past(b_wdata))); // R9
        end else if (VIEW_B == dwr_pkg::SEE_OLD) begin : g_b_old
            AST_B_READS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && rd_en && b_lane_we == '1 && b_hit) |=> (rd_data == $past(rd_word))); // R9
        end
    endgenerate

endmodule

// File: rtl/dual_wr_ram.sv
// Top level: two synchronous writers (A byte-lane, B full word) and one
// registered reader on a single clock. Lane collisions are settled by PRIO
// and same-cycle read-through follows VIEW_A / VIEW_B.
// Assumes: DATA_W is a whole multiple of BYTE_W.
module dual_wr_ram #(
    parameter int                 ADDR_W = 4,
    parameter int                 DATA_W = 16,
    parameter int                 BYTE_W = 8,
    parameter dwr_pkg::dwr_prio_e PRIO   = dwr_pkg::PRIO_A,
    parameter dwr_pkg::dwr_view_e VIEW_A = dwr_pkg::SEE_NEW,
    parameter dwr_pkg::dwr_view_e VIEW_B = dwr_pkg::SEE_OLD,
    localparam int                LANES  = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              a_we,
    input  logic [LANES-1:0]  a_be,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [LANES-1:0]  a_lane_we;
    logic [LANES-1:0]  b_lane_we;
    logic [DATA_W-1:0] rd_word;

    dwr_wr_arbiter #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .PRIO   (PRIO)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .a_we      (a_we),
        .a_be      (a_be),
        .a_addr    (a_addr),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .a_lane_we (a_lane_we),
        .b_lane_we (b_lane_we)
    );

    dwr_storage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_mem (
        .clk       (clk),
        .a_lane_we (a_lane_we),
        .a_addr    (a_addr),
        .a_wdata   (a_wdata),
        .b_lane_we (b_lane_we),
        .b_addr    (b_addr),
        .b_wdata   (b_wdata),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word)
    );

    dwr_read_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .VIEW_A (VIEW_A),
        .VIEW_B (VIEW_B)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .a_lane_we (a_lane_we),
        .a_addr    (a_addr),
        .a_wdata   (a_wdata),
        .b_lane_we (b_lane_we),
        .b_addr    (b_addr),
        .b_wdata   (b_wdata),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/tb_dual_wr_ram.sv
// Bench: three configurations share one stimulus stream. A behavioural model
// with per-lane "known" flags predicts rd_data and is compared every cycle.
module tb_dual_wr_ram;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = 8;
    localparam int NB = DW / BW;
    localparam int ND = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic a_we = 1'b0;
    logic [NB-1:0] a_be = '0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic b_we = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_q [ND];

    always #5 clk = ~clk;

    dual_wr_ram dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .a_we(a_we), .a_be(a_be),
        .a_addr(a_addr), .a_wdata(a_wdata), .b_we(b_we), .b_addr(b_addr),
        .b_wdata(b_wdata), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q[0]));

    dual_wr_ram #(.PRIO(dwr_pkg::PRIO_B), .VIEW_A(dwr_pkg::SEE_OLD), .VIEW_B(dwr_pkg::SEE_NEW)) dut_alt (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .a_we(a_we), .a_be(a_be),
        .a_addr(a_addr), .a_wdata(a_wdata), .b_we(b_we), .b_addr(b_addr),
        .b_wdata(b_wdata), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q[1]));

    dual_wr_ram #(.PRIO(dwr_pkg::PRIO_NONE), .VIEW_A(dwr_pkg::SEE_ANY), .VIEW_B(dwr_pkg::SEE_NEW)) dut_none (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .a_we(a_we), .a_be(a_be),
        .a_addr(a_addr), .a_wdata(a_wdata), .b_we(b_we), .b_addr(b_addr),
        .b_wdata(b_wdata), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q[2]));

    // Configurations: priority 0=A 1=B 2=none; view 0=old 1=new 2=any.
    int cfg_prio [ND] = '{0, 1, 2};
    int cfg_va   [ND] = '{1, 0, 2};
    int cfg_vb   [ND] = '{0, 1, 1};

    logic [DW-1:0] m_mem [ND][DEPTH];
    bit            m_kn  [ND][DEPTH][NB];
    logic [DW-1:0] m_rd  [ND];
    bit            m_rk  [ND][NB];

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    initial begin
        for (int k = 0; k < ND; k++) begin
            m_rd[k] = '0;
            for (int j = 0; j < NB; j++) m_rk[k][j] = 1'b0;
            for (int a = 0; a < DEPTH; a++) begin
                m_mem[k][a] = '0;
                for (int j = 0; j < NB; j++) m_kn[k][a][j] = 1'b0;
            end
        end
    end

    // Reference model: read from the pre-edge state, then apply the writes.
    always @(posedge clk) begin
        for (int k = 0; k < ND; k++) begin
            if (!rst_n) begin
                m_rd[k] = '0;
                for (int j = 0; j < NB; j++) m_rk[k][j] = 1'b1;
            end else if (clk_en && rd_en) begin
                for (int j = 0; j < NB; j++) begin
                    bit wa;
                    bit wb;
                    int w;
                    int view;
                    wa = a_we && a_be[j] && (a_addr == rd_addr);
                    wb = b_we && (b_addr == rd_addr);
                    w = -1;
                    if (wa && wb) w = (cfg_prio[k] == 2) ? -2 : cfg_prio[k];
                    else if (wa) w = 0;
                    else if (wb) w = 1;
                    if (w == -1) begin
                        m_rd[k][j*BW +: BW] = m_mem[k][rd_addr][j*BW +: BW];
                        m_rk[k][j] = m_kn[k][rd_addr][j];
                    end else if (w == -2) begin
                        m_rk[k][j] = 1'b0;
                    end else begin
                        view = (w == 0) ? cfg_va[k] : cfg_vb[k];
                        if (view == 1) begin
                            m_rd[k][j*BW +: BW] = (w == 0) ? a_wdata[j*BW +: BW] : b_wdata[j*BW +: BW];
                            m_rk[k][j] = 1'b1;
                        end else if (view == 0) begin
                            m_rd[k][j*BW +: BW] = m_mem[k][rd_addr][j*BW +: BW];
                            m_rk[k][j] = m_kn[k][rd_addr][j];
                        end else begin
                            m_rk[k][j] = 1'b0;
                        end
                    end
                end
            end
            if (clk_en) begin
                for (int j = 0; j < NB; j++) begin
                    bit aw;
                    bit bw;
                    aw = a_we && a_be[j];
                    bw = b_we;
                    if (aw && bw && a_addr == b_addr) begin
                        if (cfg_prio[k] == 0) begin
                            m_mem[k][a_addr][j*BW +: BW] = a_wdata[j*BW +: BW];
                            m_kn[k][a_addr][j] = 1'b1;
                        end else if (cfg_prio[k] == 1) begin
                            m_mem[k][b_addr][j*BW +: BW] = b_wdata[j*BW +: BW];
                            m_kn[k][b_addr][j] = 1'b1;
                        end else begin
                            m_kn[k][a_addr][j] = 1'b0;
                        end
                    end else begin
                        if (aw) begin
                            m_mem[k][a_addr][j*BW +: BW] = a_wdata[j*BW +: BW];
                            m_kn[k][a_addr][j] = 1'b1;
                        end
                        if (bw) begin
                            m_mem[k][b_addr][j*BW +: BW] = b_wdata[j*BW +: BW];
                            m_kn[k][b_addr][j] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < ND; k++) begin
                bit bad;
                bad = 1'b0;
                for (int j = 0; j < NB; j++)
                    if (m_rk[k][j] && rd_q[k][j*BW +: BW] !== m_rd[k][j*BW +: BW]) bad = 1'b1;
                checks++;
                if (bad) begin
                    fails++;
                    $display("FAIL %s cfg%0d cycle %0d: rd_data actual %h expected %h (lanes known %0d%0d)",
                             tag, k, cyc, rd_q[k], m_rd[k], m_rk[k][1], m_rk[k][0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog: actual still running at cycle %0d, expected finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input bit ce, input bit awe, input logic [NB-1:0] abe,
                        input int aa, input logic [DW-1:0] ad, input bit bwe,
                        input int ba, input logic [DW-1:0] bd, input bit re, input int ra);
        clk_en = ce; a_we = awe; a_be = abe; a_addr = AW'(aa); a_wdata = ad;
        b_we = bwe; b_addr = AW'(ba); b_wdata = bd; rd_en = re; rd_addr = AW'(ra);
        @(negedge clk);
    endtask

    task automatic rd(input int ra);
        step(1, 0, '0, 0, '0, 0, 0, '0, 1, ra);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset dominates an enabled read.
        tag = "R1";
        rst_n = 1'b0;
        step(1, 0, '0, 0, '0, 0, 0, '0, 1, 0);
        step(1, 0, '0, 0, '0, 0, 0, '0, 1, 5);
        step(0, 0, '0, 0, '0, 0, 0, '0, 0, 0);
        for (int k = 0; k < ND; k++) begin
            checks++;
            if (rd_q[k] !== '0) begin
                fails++;
                $display("FAIL R1 cfg%0d: rd_data actual %h expected 0000", k, rd_q[k]);
            end
        end
        rst_n = 1'b1;

        // R4: fill every word through port B.
        tag = "R4";
        for (int a = 0; a < DEPTH; a++) step(1, 0, '0, 0, '0, 1, a, DW'(16'h1111 * a ^ 16'h5A3C), 0, 0);
        // R2: read everything back, then idle with reads disabled.
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) rd(a);
        step(1, 0, '0, 0, '0, 0, 0, '0, 0, 9);
        step(1, 0, '0, 0, '0, 0, 0, '0, 0, 3);

        // R3: lane-qualified writes on port A.
        tag = "R3";
        step(1, 1, 2'b01, 2, 16'hBEEF, 0, 0, '0, 0, 0);
        step(1, 1, 2'b10, 3, 16'hCAFE, 0, 0, '0, 0, 0);
        step(1, 1, 2'b00, 4, 16'hDEAD, 0, 0, '0, 0, 0);
        step(1, 0, 2'b11, 5, 16'hF00D, 0, 0, '0, 0, 0);
        for (int a = 2; a <= 5; a++) rd(a);

        // R5: clock enable low blocks both writers and the read.
        tag = "R5";
        step(0, 1, 2'b11, 6, 16'h1234, 1, 7, 16'h5678, 1, 6);
        step(0, 0, '0, 0, '0, 0, 0, '0, 1, 7);
        rd(6);
        rd(7);

        // R6: two writers, two addresses, same cycle.
        tag = "R6";
        step(1, 1, 2'b11, 8, 16'hA1A2, 1, 9, 16'hB1B2, 0, 0);
        rd(8);
        rd(9);

        // R7: collisions, full and partial lane enables.
        tag = "R7";
        step(1, 1, 2'b11, 10, 16'hAAAA, 1, 10, 16'hBBBB, 0, 0);
        step(1, 1, 2'b01, 11, 16'hA0A1, 1, 11, 16'hB0B1, 0, 0);
        rd(10);
        rd(11);

        // R8: same-cycle read of a cell one port writes.
        tag = "R8";
        step(1, 1, 2'b11, 12, 16'h7E57, 0, 0, '0, 1, 12);
        step(1, 0, '0, 0, '0, 1, 13, 16'h0B0B, 1, 13);
        step(1, 1, 2'b10, 14, 16'h4411, 0, 0, '0, 1, 14);
        rd(12);
        rd(13);
        rd(14);

        // R9: collision on the cell being read.
        tag = "R9";
        step(1, 1, 2'b11, 15, 16'h9A9A, 1, 15, 16'h9B9B, 1, 15);
        step(1, 1, 2'b10, 15, 16'h8A8A, 1, 15, 16'h8B8B, 1, 15);
        rd(15);

        // R9: mixed random traffic on a narrow address window.
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 8) != 0, $urandom % 2, NB'($urandom), $urandom % 4, DW'($urandom),
                 $urandom % 2, $urandom % 4, DW'($urandom), $urandom % 2, $urandom % 4);
        end

        step(0, 0, '0, 0, '0, 0, 0, '0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule